// File: doc/BRIEF.md
# Card-Detect Sticky Interrupt Register

This block is a small board-control register window on a 32-bit register bus. It returns two fixed words, a board identity and a decode-configuration code, and holds one interrupt register that serves a removable memory card socket. The socket provides two level inputs: a write-protect switch and a card-present detector.

The write-protect level is shown live in the interrupt register. A rising edge on the card-present input sets a sticky insertion flag. That flag drives the interrupt output until software writes a one to its bit position. A word for flash programming control reads zero and drops writes. Every offset outside the four decoded words reads zero and drops writes.

Reads are combinational. Read data is valid in the same cycle that the read strobe and address are presented, and it is zero when no read is requested. Writes take effect at the next rising clock edge.

Top module: `cdreg_ctrl`

## Requirements
- R1: A read of byte address 0x00 (word 0) returns 0x41034003, and a write to it does not change that value.
- R2: A read of byte address 0x0C (word 3) returns 0x00000011, and a write to it does not change that value.
- R3: A read of byte address 0x04 (word 1, flash programming control) returns zero, and writes to it are dropped.
- R4: In a read of byte address 0x08 (word 2, interrupt register), bit 0 equals the card_wp_i level in the same cycle.
- R5: When card_in_i is high at a clock edge and was low at the previous edge, the insertion flag (bit 3 of word 2) is set after that edge. The input counts as low at reset. The flag stays set after card_in_i falls.
- R6: A write to word 2 with wdata bit 3 high clears the insertion flag at the next edge. A write with bit 3 low leaves the flag unchanged. Bits of word 2 other than 0 and 3 read zero.
- R7: irq_o equals the insertion flag, and bit 3 of a word-2 read equals irq_o.
- R8: A card_in_i held high after a clearing write does not set the flag again until the input falls and rises again.
- R9: When an insertion edge and a clearing write fall on the same clock edge, the flag ends up set.
- R10: Reads of any word index 4 and above return zero, and writes there are dropped. bus_rdata_o is zero while bus_rd_i is low. Reset clears the insertion flag and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | AW (8) | Byte address within the window |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data, combinational |
| card_wp_i | input | 1 | Card write-protect switch level |
| card_in_i | input | 1 | Card-present detector level |
| irq_o | output | 1 | Card insertion interrupt |

## Verification
An insertion edge on card_in_i and a software write that clears the insertion flag can land on the same clock edge. The bench provokes this from a table entry. In that entry card_in_i goes from low to high in the same cycle as a word-2 write with bit 3 set. The design passes if irq_o is high after the edge and a following read shows bit 3 set. Separate entries cover the cases where only one of the two events occurs, and the case where the clear happens while the input is held high, which must leave the flag cleared.

// File: rtl/cdreg_pkg.sv
package cdreg_pkg;
  localparam int unsigned NUM_WORDS   = 4;
  localparam int unsigned W_ID        = 0;
  localparam int unsigned W_FLASH     = 1;
  localparam int unsigned W_INTR      = 2;
  localparam int unsigned W_DECODE    = 3;
  localparam int unsigned BIT_WP      = 0;
  localparam int unsigned BIT_CARD    = 3;
  localparam logic [31:0] ID_DEFAULT  = 32'h4103_4003;
  localparam logic [31:0] DEC_DEFAULT = 32'h0000_0011;
endpackage

// File: rtl/cdreg_decode.sv
module cdreg_decode
  import cdreg_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0]        addr_i,
  output logic [NUM_WORDS-1:0] hit_o
);
  localparam int unsigned WW = AW - 2;

  logic [WW-1:0] word_idx;
  logic [1:0]    unused_lsb;

  assign word_idx   = addr_i[AW-1:2];
  assign unused_lsb = addr_i[1:0];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_hit
    assign hit_o[k] = (word_idx == WW'(k));
  end
endmodule

// File: rtl/cdreg_card_latch.sv
module cdreg_card_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic card_in_i,
  input  logic clr_req_i,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;
  logic rise;

  assign rise = card_in_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= card_in_i;
      // set wins over a same-cycle clear
      if (rise)           flag_q <= 1'b1;
      else if (clr_req_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cdreg_rdmux.sv
module cdreg_rdmux
  import cdreg_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter logic [DW-1:0] ID_VALUE  = DW'(ID_DEFAULT),
  parameter logic [DW-1:0] DEC_VALUE = DW'(DEC_DEFAULT)
) (
  input  logic                 rd_i,
  input  logic [NUM_WORDS-1:0] hit_i,
  input  logic                 wp_i,
  input  logic                 flag_i,
  output logic [DW-1:0]        rdata_o
);
  logic [DW-1:0] intr_word;

  always_comb begin
    intr_word           = '0;
    intr_word[BIT_WP]   = wp_i;
    intr_word[BIT_CARD] = flag_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (hit_i[W_ID])          rdata_o = ID_VALUE;
      else if (hit_i[W_INTR])   rdata_o = intr_word;
      else if (hit_i[W_DECODE]) rdata_o = DEC_VALUE;
    end
  end
endmodule

// File: rtl/cdreg_ctrl.sv
module cdreg_ctrl
  import cdreg_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  parameter logic [DW-1:0] ID_VALUE  = DW'(ID_DEFAULT),
  parameter logic [DW-1:0] DEC_VALUE = DW'(DEC_DEFAULT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_rd_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          card_wp_i,
  input  logic          card_in_i,
  output logic          irq_o
);
  logic [NUM_WORDS-1:0] hit;
  logic                 clr_req;
  logic                 flag;
  logic                 unused_wdata;

  assign unused_wdata = ^{bus_wdata_i[DW-1:BIT_CARD+1], bus_wdata_i[BIT_CARD-1:0]};

  cdreg_decode #(.AW(AW)) u_decode (
    .addr_i (bus_addr_i),
    .hit_o  (hit)
  );

  // flash-control and decode words take writes without effect
  assign clr_req = bus_wr_i & hit[W_INTR] & bus_wdata_i[BIT_CARD];

  cdreg_card_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .card_in_i (card_in_i),
    .clr_req_i (clr_req),
    .flag_o    (flag)
  );

  cdreg_rdmux #(.DW(DW), .ID_VALUE(ID_VALUE), .DEC_VALUE(DEC_VALUE)) u_rdmux (
    .rd_i    (bus_rd_i),
    .hit_i   (hit),
    .wp_i    (card_wp_i),
    .flag_i  (flag),
    .rdata_o (bus_rdata_o)
  );

  assign irq_o = flag;
endmodule

// File: rtl/cdreg_ctrl_chk.sv
module cdreg_ctrl_chk #(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  parameter logic [DW-1:0] ID_VALUE  = '0,
  parameter logic [DW-1:0] DEC_VALUE = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_rd_i,
  input logic          bus_wr_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic [DW-1:0] bus_rdata_o,
  input logic          card_wp_i,
  input logic          card_in_i,
  input logic          irq_o
);
  localparam int unsigned WW = AW - 2;

  logic          seen_q;
  logic          rise;
  logic          clr;
  logic [WW-1:0] w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= card_in_i;
  end

  assign w    = bus_addr_i[AW-1:2];
  assign rise = card_in_i && !seen_q;
  assign clr  = bus_wr_i && (w == WW'(2)) && bus_wdata_i[3];

  AST_ID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && w == WW'(0) |-> bus_rdata_o == ID_VALUE); // R1
  AST_DECODE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && w == WW'(3) |-> bus_rdata_o == DEC_VALUE); // R2
  AST_FLASH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && w == WW'(1) |-> bus_rdata_o == '0); // R3
  AST_WP_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && w == WW'(2) |-> bus_rdata_o[0] == card_wp_i); // R4
  AST_SET_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> irq_o); // R5 R9
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr |=> irq_o); // R5
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && clr && !rise |=> !irq_o); // R6
  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && w == WW'(2) |-> bus_rdata_o[3] == irq_o); // R7
  AST_NO_RESET_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !rise |=> !irq_o); // R8
  AST_OTHER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && w >= WW'(4) |-> bus_rdata_o == '0); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> bus_rdata_o == '0); // R10
endmodule

bind cdreg_ctrl cdreg_ctrl_chk #(
  .AW(AW), .DW(DW), .ID_VALUE(ID_VALUE), .DEC_VALUE(DEC_VALUE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .card_wp_i   (card_wp_i),
  .card_in_i   (card_in_i),
  .irq_o       (irq_o)
);

// File: tb/cdreg_ctrl_test.sv
module cdreg_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  typedef struct packed {
    logic        wp;
    logic        card;
    logic        wr;
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  // exp_rd checked before the edge, exp_irq after it
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,8'h00,32'h0,32'h4103_4003,1'b0,4'd1},  // R1
    '{1'b0,1'b0,1'b0,1'b1,8'h0C,32'h0,32'h11,1'b0,4'd2},         // R2
    '{1'b0,1'b0,1'b0,1'b1,8'h04,32'h0,32'h0,1'b0,4'd3},          // R3
    '{1'b1,1'b0,1'b0,1'b1,8'h08,32'h0,32'h1,1'b0,4'd4},          // R4
    '{1'b1,1'b1,1'b0,1'b1,8'h08,32'h0,32'h1,1'b1,4'd5},          // R5 rise
    '{1'b0,1'b1,1'b0,1'b1,8'h08,32'h0,32'h8,1'b1,4'd7},          // R7
    '{1'b0,1'b0,1'b0,1'b1,8'h08,32'h0,32'h8,1'b1,4'd5},          // R5 sticky
    '{1'b0,1'b0,1'b1,1'b0,8'h08,32'h7,32'h0,1'b1,4'd6},          // R6 no bit3
    '{1'b1,1'b0,1'b0,1'b1,8'h08,32'h0,32'h9,1'b1,4'd6},
    '{1'b0,1'b0,1'b1,1'b0,8'h08,32'h8,32'h0,1'b0,4'd6},          // R6 clear
    '{1'b0,1'b0,1'b0,1'b1,8'h08,32'h0,32'h0,1'b0,4'd7},
    '{1'b0,1'b1,1'b0,1'b1,8'h08,32'h0,32'h0,1'b1,4'd5},
    '{1'b0,1'b1,1'b1,1'b0,8'h08,32'h8,32'h0,1'b0,4'd6},
    '{1'b0,1'b1,1'b0,1'b1,8'h08,32'h0,32'h0,1'b0,4'd8},          // R8 held
    '{1'b0,1'b1,1'b0,1'b0,8'h08,32'h0,32'h0,1'b0,4'd8},
    '{1'b0,1'b0,1'b1,1'b0,8'h0C,32'hFFFF_FFFF,32'h0,1'b0,4'd2},
    '{1'b0,1'b0,1'b0,1'b1,8'h0C,32'h0,32'h11,1'b0,4'd2},
    '{1'b0,1'b0,1'b1,1'b0,8'h04,32'hFFFF_FFFF,32'h0,1'b0,4'd3},
    '{1'b0,1'b0,1'b0,1'b1,8'h04,32'h0,32'h0,1'b0,4'd3},
    '{1'b0,1'b0,1'b1,1'b0,8'h40,32'hFFFF_FFFF,32'h0,1'b0,4'd10}, // R10
    '{1'b0,1'b0,1'b0,1'b1,8'h40,32'h0,32'h0,1'b0,4'd10},
    '{1'b0,1'b0,1'b1,1'b0,8'h00,32'h0,32'h0,1'b0,4'd1},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,32'h0,32'h4103_4003,1'b0,4'd1},
    '{1'b0,1'b1,1'b1,1'b0,8'h08,32'h8,32'h0,1'b1,4'd9},          // R9 set wins
    '{1'b0,1'b0,1'b0,1'b1,8'h08,32'h0,32'h8,1'b1,4'd9},
    '{1'b0,1'b0,1'b1,1'b0,8'h08,32'hFFFF_FFFF,32'h0,1'b0,4'd6}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        card_wp_i = 1'b0;
  logic        card_in_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cdreg_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .card_wp_i(card_wp_i), .card_in_i(card_in_i), .irq_o(irq_o)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wp, input logic card, input logic wr, input logic rd,
                       input logic [7:0] addr, input logic [31:0] wd);
    card_wp_i = wp; card_in_i = card; bus_wr_i = wr; bus_rd_i = rd;
    bus_addr_i = addr; bus_wdata_i = wd;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state, R10
    repeat (2) @(negedge clk_i);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h08, 32'h0);
    #1;
    check32("R10 reset irq", {31'b0, irq_o}, 32'h0);
    check32("R10 reset intreg", bus_rdata_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    foreach (VECS[i]) begin
      string tag;
      @(negedge clk_i);
      drive(VECS[i].wp, VECS[i].card, VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].wdata);
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      #1;
      check32({tag, " rdata"}, bus_rdata_o, VECS[i].exp_rd);
      @(posedge clk_i);
      #2;
      check32({tag, " irq"}, {31'b0, irq_o}, {31'b0, VECS[i].exp_irq});
    end

    // R10: reset clears a set flag
    @(negedge clk_i);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 32'h0);
    @(negedge clk_i);
    check32("R5 pre-reset set", {31'b0, irq_o}, 32'h1);
    rst_ni = 1'b0;
    #1;
    check32("R10 async reset clears", {31'b0, irq_o}, 32'h0);
    // R5: input high at reset release counts as a rise
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check32("R5 high at release", {31'b0, irq_o}, 32'h1);

    // R6: clear leaves wp bit live
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h08, 32'h8);
    @(negedge clk_i);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h08, 32'h0);
    #1;
    check32("R6 cleared, wp kept", bus_rdata_o, 32'h1);
    // R10: alias of word 2 beyond the decoded range does not clear
    @(negedge clk_i);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0);
    @(negedge clk_i);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 32'h0);
    @(negedge clk_i);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h48, 32'hFFFF_FFFF);
    @(negedge clk_i);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h08, 32'h0);
    #1;
    check32("R10 high offset write ignored", bus_rdata_o, 32'h8);

    @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule